// File: doc/BRIEF.md
# Flash Sector-Erase Command Sequencer

This block is the command front end of a parallel NOR flash model. It watches the write cycles on the device bus and recognises the six-write sector-erase command. It then opens a timed acceptance window. Each further sector-erase write that arrives inside the window adds a sector to the erase set and restarts the window. When the window runs out, the block erases the chosen sectors one after another, lowest sector index first, using a modelled per-sector erase time.

An erase can be suspended and later resumed. A suspend that arrives inside the window takes effect at once. A suspend that arrives during the erase takes effect after a fixed latency. While the erase is suspended, reads of sectors in the erase set return a status byte. Reads of any other sector return array data.

The array itself is a stub: one flag per sector records whether that sector has been erased. A program read of an erased sector returns 0xFF and any other sector returns 0x00. The design is fully synchronous. A write is taken on the clock edge at which `we_i` is high. The parameters `WIN_CYC`, `ERASE_CYC` and `SUSP_LAT` set the timing in clock cycles.

Top module: `flash_sector_erase`

## Requirements
- R1: After reset `ready_o` is 1, and reads of every sector return array data 0x00 (no sector erased).
- R2: The sector erase starts only after these six writes in order: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x30@sector. Unlock addresses are compared on `addr_i[10:0]`, and the sector index is `addr_i[ADDR_W-1 -: log2(SECT_N)]`. `ready_o` is 0 from the edge of the final write onward.
- R3: The acceptance window lasts `WIN_CYC` cycles, counted from the edge of the last accepted write. Status bit 3 is 0 inside the window and becomes 1 `WIN_CYC` edges after that write.
- R4: Each selected sector takes `ERASE_CYC` cycles, in ascending index order. With n sectors, `ready_o` returns to 1 exactly `WIN_CYC + n*ERASE_CYC` edges after the last accepted window write. Erased sectors then read 0xFF, and the erase set is cleared.
- R5: A 0x30 write inside the window adds its sector to the erase set and restarts the window.
- R6: While the block is busy (window, erase, or suspend pending), a read of any address returns the status byte. Its bits are: 7 = suspended, 6 = busy, 3 = erase started, 2 = the read sector is in the erase set, and all other bits 0.
- R7: A write that does not match the expected step returns the decoder to the first step, so no erase starts. A correct sequence written afterwards works.
- R8: Inside the window, any write other than 0x30 or 0xB0 cancels the sequence. `ready_o` goes to 1 on the next edge, and no sector is erased.
- R9: Once the erase has started, any write other than 0xB0 is ignored, and the completion cycle does not change.
- R10: A 0xB0 write inside the window suspends at once (`ready_o`=1 on the next edge, with status bit 3 still 0). A 0xB0 write while idle in read-array mode is ignored.
- R11: A 0xB0 write during the erase suspends after `SUSP_LAT` edges. The erase keeps running while the suspend is pending. A later 0x30 write resumes the erase, which continues from the remaining time of the current sector.
- R12: While suspended, reads of selected sectors return status with bit 7 set, and reads of unselected sectors return array data.
- R13: Asserting `rst_ni` during an erase aborts it at once. `ready_o` goes to 1, and the interrupted sector is left unerased.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Bus write strobe, one write per cycle high |
| addr_i | input | ADDR_W | Write address |
| wdata_i | input | 8 | Write data / command byte |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 8 | Array data or status byte |
| ready_o | output | 1 | 1 = ready, 0 = busy |

## Verification
Every write takes effect on the clock edge at which `we_i` is high. State changes caused by a write are therefore visible at the falling edge that follows, and the read path is combinational from `rd_addr_i`. The bench drives and samples only on falling edges and counts edges from the final accepted write. The window expires `WIN_CYC` edges after that write, and each sector completes `ERASE_CYC` edges after the previous one. A pending suspend lands `SUSP_LAT` edges after the 0xB0 write. For each of these events the bench checks the cycle just before the expected edge and the cycle just after it, so an off-by-one in any counter shows up.

// File: rtl/fse_pkg.sv
package fse_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned UNLK_W = 11;

  localparam logic [DATA_W-1:0] CMD_UNLK1 = 8'hAA;
  localparam logic [DATA_W-1:0] CMD_UNLK2 = 8'h55;
  localparam logic [DATA_W-1:0] CMD_SETUP = 8'h80;
  localparam logic [DATA_W-1:0] CMD_SERASE = 8'h30;
  localparam logic [DATA_W-1:0] CMD_SUSP = 8'hB0;

  localparam logic [UNLK_W-1:0] ADR_UNLK1 = 11'h555;
  localparam logic [UNLK_W-1:0] ADR_UNLK2 = 11'h2AA;

  localparam int unsigned SB_SUSP = 7;
  localparam int unsigned SB_BUSY = 6;
  localparam int unsigned SB_STARTED = 3;
  localparam int unsigned SB_SEL = 2;

  typedef enum logic [2:0] {
    ST_READ,
    ST_WINDOW,
    ST_ERASE,
    ST_SUSP_WAIT,
    ST_SUSPENDED
  } fse_state_e;
endpackage

// File: rtl/fse_cmd_decode.sv
module fse_cmd_decode
  import fse_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              erase_req_o
);
  localparam int unsigned LAST_STEP = 5;

  logic [2:0] step_q;
  logic       match;
  logic       is_u1, is_u2;

  assign is_u1 = (wdata_i == CMD_UNLK1) && (addr_i[UNLK_W-1:0] == ADR_UNLK1);
  assign is_u2 = (wdata_i == CMD_UNLK2) && (addr_i[UNLK_W-1:0] == ADR_UNLK2);

  always_comb begin
    unique case (step_q)
      3'd0, 3'd3: match = is_u1;
      3'd1, 3'd4: match = is_u2;
      3'd2:       match = (wdata_i == CMD_SETUP) && (addr_i[UNLK_W-1:0] == ADR_UNLK1);
      3'd5:       match = (wdata_i == CMD_SERASE);
      default:    match = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     step_q <= '0;
    else if (!en_i)                                  step_q <= '0;
    else if (we_i && match && step_q != 3'(LAST_STEP)) step_q <= step_q + 3'd1;
    else if (we_i)                                   step_q <= '0;
  end

  assign erase_req_o = en_i && we_i && match && (step_q == 3'(LAST_STEP));

  // any mismatching write restarts the sequence
  p_mismatch_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && we_i && !match) |=> (step_q == 3'd0));
  p_step_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= 3'(LAST_STEP));
endmodule

// File: rtl/fse_down_timer.sv
module fse_down_timer #(
  parameter int unsigned LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic zero_o
);
  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] TOP = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= TOP;
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TOP);
  p_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == TOP));
endmodule

// File: rtl/flash_sector_erase.sv
module flash_sector_erase
  import fse_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned SECT_N    = 8,
  parameter int unsigned WIN_CYC   = 8,
  parameter int unsigned ERASE_CYC = 12,
  parameter int unsigned SUSP_LAT  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              ready_o
);
  localparam int unsigned SB = (SECT_N > 1) ? $clog2(SECT_N) : 1;
  localparam logic [SECT_N-1:0] ONE = {{(SECT_N-1){1'b0}}, 1'b1};

  fse_state_e state_q, state_d;
  logic [SECT_N-1:0] sel_q, sel_d, era_q, era_d;
  logic started_q, started_d;

  logic erase_req, win_zero, ers_zero, lat_zero;
  logic win_load, ers_load, ers_run, lat_load, sect_done;
  logic wr_susp, wr_se;
  logic [SECT_N-1:0] wr_onehot, lowbit, sel_left;

  assign wr_susp   = we_i && (wdata_i == CMD_SUSP);
  assign wr_se     = we_i && (wdata_i == CMD_SERASE);
  assign wr_onehot = ONE << addr_i[ADDR_W-1 -: SB];
  assign lowbit    = sel_q & (~sel_q + ONE);
  assign sel_left  = sel_q & ~lowbit;

  fse_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk_i, .rst_ni,
    .en_i       (state_q == ST_READ),
    .we_i, .addr_i, .wdata_i,
    .erase_req_o(erase_req)
  );

  assign ers_run   = (state_q == ST_ERASE) || (state_q == ST_SUSP_WAIT);
  assign sect_done = ers_run && ers_zero;
  assign ers_load  = (state_q == ST_WINDOW) || sect_done;
  assign lat_load  = (state_q == ST_ERASE) && wr_susp;

  fse_down_timer #(.LEN(WIN_CYC)) u_win (
    .clk_i, .rst_ni, .load_i(win_load), .run_i(state_q == ST_WINDOW), .zero_o(win_zero));
  fse_down_timer #(.LEN(ERASE_CYC)) u_ers (
    .clk_i, .rst_ni, .load_i(ers_load), .run_i(ers_run), .zero_o(ers_zero));
  fse_down_timer #(.LEN(SUSP_LAT)) u_lat (
    .clk_i, .rst_ni, .load_i(lat_load), .run_i(state_q == ST_SUSP_WAIT), .zero_o(lat_zero));

  always_comb begin
    state_d  = state_q;
    sel_d    = sel_q;
    era_d    = era_q;
    win_load = 1'b0;
    unique case (state_q)
      ST_READ: if (erase_req) begin
        state_d  = ST_WINDOW;
        sel_d    = wr_onehot;
        win_load = 1'b1;
      end
      ST_WINDOW: begin
        if (wr_susp) state_d = ST_SUSPENDED;
        else if (wr_se) begin
          sel_d    = sel_q | wr_onehot;
          win_load = 1'b1;
        end else if (we_i) begin
          state_d = ST_READ;
          sel_d   = '0;
        end else if (win_zero) state_d = ST_ERASE;
      end
      ST_ERASE, ST_SUSP_WAIT: begin
        if (sect_done) begin
          sel_d = sel_left;
          era_d = era_q | lowbit;
        end
        if (sect_done && sel_left == '0)                     state_d = ST_READ;
        else if (state_q == ST_ERASE && wr_susp)             state_d = ST_SUSP_WAIT;
        else if (state_q == ST_SUSP_WAIT && lat_zero)        state_d = ST_SUSPENDED;
      end
      ST_SUSPENDED: if (wr_se) state_d = ST_ERASE;
      default: state_d = ST_READ;
    endcase
  end

  always_comb begin
    started_d = started_q;
    if (state_d == ST_ERASE)     started_d = 1'b1;
    else if (state_d == ST_READ) started_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_READ;
      sel_q     <= '0;
      era_q     <= '0;
      started_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      sel_q     <= sel_d;
      era_q     <= era_d;
      started_q <= started_d;
    end
  end

  // read path: status while busy or in a suspended selected sector
  logic [SB-1:0] rd_sec;
  logic busy, show_status;
  logic [7:0] status;
  logic unused_rd;

  assign rd_sec    = rd_addr_i[ADDR_W-1 -: SB];
  assign unused_rd = ^rd_addr_i[ADDR_W-SB-1:0];
  assign busy      = (state_q == ST_WINDOW) || ers_run;
  assign ready_o   = !busy;
  assign show_status = busy || (state_q == ST_SUSPENDED && sel_q[rd_sec]);

  always_comb begin
    status = '0;
    status[SB_SUSP]    = (state_q == ST_SUSPENDED);
    status[SB_BUSY]    = busy;
    status[SB_STARTED] = started_q;
    status[SB_SEL]     = sel_q[rd_sec];
  end

  assign rd_data_o = show_status ? status : (era_q[rd_sec] ? 8'hFF : 8'h00);

  p_idle_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READ) |-> (sel_q == '0));
  p_started_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(started_q) |-> ($past(state_q) == ST_WINDOW || $past(state_q) == ST_SUSPENDED));
  p_cancel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WINDOW && we_i && !wr_se && !wr_susp) |=> (state_q == ST_READ && sel_q == '0));
  p_ignore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERASE && we_i && !wr_susp) |=> (state_q == ST_ERASE || state_q == ST_READ));
  p_susp_now_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WINDOW && wr_susp) |=> (state_q == ST_SUSPENDED && !started_q));
  p_resume_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SUSPENDED && wr_se) |=> (state_q == ST_ERASE));
  p_frozen_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SUSPENDED) |=> ($stable(sel_q) && $stable(era_q)));
  p_erase_subset_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (era_q != $past(era_q)) |-> $onehot0(era_q ^ $past(era_q)));
endmodule

// File: tb/flash_sector_erase_tb.sv
module flash_sector_erase_tb;
  localparam int W = 8;
  localparam int E = 12;
  localparam int L = 4;
  localparam logic [7:0] S_SUSP = 8'h80, S_BUSY = 8'h40, S_STRT = 8'h08, S_SEL = 8'h04;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [11:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic ready;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_sector_erase #(.ADDR_W(12), .SECT_N(8), .WIN_CYC(W), .ERASE_CYC(E), .SUSP_LAT(L)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .ready_o(ready));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // caller sits at a falling edge; write lands on the next rising edge
  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  function automatic logic [11:0] sa(input int s);
    return {s[2:0], 9'h000};
  endfunction

  task automatic rd(input int s, output logic [7:0] v);
    rd_addr = sa(s);
    #1 v = rd_data;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic se_seq(input int s);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(sa(s), 8'h30);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    do_reset();
    chk("R1 ready after reset", ready, 1);
    for (int s = 0; s < 8; s++) begin
      rd(s, v);
      chk("R1 array after reset", v, 8'h00);
    end
  endtask

  task automatic t_single;
    logic [7:0] v;
    do_reset();
    se_seq(3);
    chk("R2 busy after final write", ready, 0);
    rd(3, v); chk("R6 window status sel", v, S_BUSY | S_SEL);
    rd(0, v); chk("R6 window status other", v, S_BUSY);
    tick(W - 1);
    rd(3, v); chk("R3 still in window", v, S_BUSY | S_SEL);
    tick(1);
    rd(3, v); chk("R3 erase started", v, S_BUSY | S_STRT | S_SEL);
    tick(E - 1);
    chk("R4 busy before done", ready, 0);
    tick(1);
    chk("R4 ready at done", ready, 1);
    rd(3, v); chk("R4 erased sector", v, 8'hFF);
    rd(2, v); chk("R4 other sector", v, 8'h00);
  endtask

  task automatic t_multi;
    logic [7:0] v;
    do_reset();
    se_seq(6);
    wr(sa(1), 8'h30);
    tick(W - 1);
    rd(1, v); chk("R5 window restarted", v & S_STRT, 0);
    tick(1);
    rd(1, v); chk("R5 started after restart", v & S_STRT, S_STRT);
    tick(E);
    rd(1, v); chk("R4 low sector first", v & S_SEL, 0);
    rd(6, v); chk("R4 high sector pending", v & S_SEL, S_SEL);
    tick(E - 1);
    chk("R4 busy before 2nd done", ready, 0);
    tick(1);
    chk("R4 ready after two sectors", ready, 1);
    rd(1, v); chk("R4 sector1 erased", v, 8'hFF);
    rd(6, v); chk("R5 sector6 erased", v, 8'hFF);
    rd(0, v); chk("R4 sector0 kept", v, 8'h00);
  endtask

  task automatic t_bad_seq;
    do_reset();
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h54); wr(sa(3), 8'h30);
    chk("R7 broken sequence no erase", ready, 1);
    wr(12'h555, 8'hAA); wr(12'h2A0, 8'h55); wr(sa(3), 8'h30);
    chk("R7 wrong address no erase", ready, 1);
    se_seq(3);
    chk("R7 recovery sequence", ready, 0);
  endtask

  task automatic t_cancel;
    logic [7:0] v;
    do_reset();
    se_seq(4);
    tick(2);
    wr(sa(4), 8'hF0);
    chk("R8 cancel ready", ready, 1);
    rd(4, v); chk("R8 cancel array read", v, 8'h00);
    tick(W + E + 2);
    rd(4, v); chk("R8 no erase after cancel", v, 8'h00);
    chk("R8 stays ready", ready, 1);
  endtask

  task automatic t_ignore;
    logic [7:0] v;
    do_reset();
    se_seq(2);
    tick(W);
    wr(sa(5), 8'hF0);
    wr(12'h555, 8'hAA);
    wr(sa(5), 8'h30);
    rd(5, v); chk("R9 no sector added", v & S_SEL, 0);
    tick(E - 4);
    chk("R9 busy before done", ready, 0);
    tick(1);
    chk("R9 done on time", ready, 1);
    rd(5, v); chk("R9 sector5 untouched", v, 8'h00);
    rd(2, v); chk("R9 sector2 erased", v, 8'hFF);
  endtask

  task automatic t_susp_window;
    logic [7:0] v;
    do_reset();
    se_seq(5);
    wr(12'h000, 8'hB0);
    chk("R10 immediate suspend", ready, 1);
    rd(5, v); chk("R10 suspended status", v, S_SUSP | S_SEL);
    rd(0, v); chk("R12 unselected array", v, 8'h00);
    tick(W + 2);
    rd(5, v); chk("R10 stays suspended", v, S_SUSP | S_SEL);
    wr(12'h000, 8'h30);
    chk("R11 resume busy", ready, 0);
    tick(E - 1);
    chk("R11 busy before done", ready, 0);
    tick(1);
    chk("R11 done after resume", ready, 1);
    rd(5, v); chk("R11 sector5 erased", v, 8'hFF);
  endtask

  task automatic t_susp_idle;
    logic [7:0] v;
    do_reset();
    wr(sa(0), 8'hB0);
    chk("R10 idle suspend ignored", ready, 1);
    rd(0, v); chk("R10 idle read array", v, 8'h00);
    se_seq(1);
    rd(1, v); chk("R10 sequence after idle suspend", v, S_BUSY | S_SEL);
  endtask

  task automatic t_susp_erase;
    logic [7:0] v;
    int used;
    do_reset();
    se_seq(1);
    tick(W + 1);
    wr(12'h7FF, 8'hB0);
    chk("R11 pending still busy", ready, 0);
    tick(L - 1);
    rd(1, v); chk("R11 latency not over", v, S_BUSY | S_STRT | S_SEL);
    tick(1);
    chk("R11 suspended after latency", ready, 1);
    rd(1, v); chk("R12 selected gives status", v, S_SUSP | S_STRT | S_SEL);
    rd(4, v); chk("R12 unselected gives array", v, 8'h00);
    tick(5);
    wr(sa(7), 8'h30);
    used = 2 + L;
    tick(E - used - 1);
    chk("R11 busy before remaining done", ready, 0);
    tick(1);
    chk("R11 remaining time only", ready, 1);
    rd(1, v); chk("R11 sector1 erased", v, 8'hFF);
  endtask

  task automatic t_hw_reset;
    logic [7:0] v;
    do_reset();
    se_seq(7);
    tick(W + 3);
    rst_n = 1'b0;
    #1 chk("R13 reset aborts at once", ready, 1);
    tick(1);
    rst_n = 1'b1;
    tick(1);
    rd(7, v); chk("R13 sector not erased", v, 8'h00);
    tick(W + E);
    chk("R13 no erase resumes", ready, 1);
    rd(7, v); chk("R13 sector still intact", v, 8'h00);
  endtask

  initial begin
    tick(1);
    t_reset();
    t_single();
    t_multi();
    t_bad_seq();
    t_cancel();
    t_ignore();
    t_susp_window();
    t_susp_idle();
    t_susp_erase();
    t_hw_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule